// File: doc/BRIEF.md
# Two-Wire Register Slave with Pointer Auto-Advance

This block is a target on a two-wire serial bus with a clock line and an open-drain data line. It holds a small bank of 8-bit registers behind an 8-bit register pointer. A host writes by selecting the slave with a write header and sending one byte that loads the pointer. Any further bytes in the same cycle are stored at the pointer, and the pointer steps after each one. To read, the host sends a repeated start and a read header, then clocks bytes out. The slave supplies bytes from successive registers for as long as the host acknowledges them.

Two pointers follow different advance rules. The register pointer steps during a read only when the host acknowledges a byte. The coefficient RAM pointer steps after every completed byte read through the coefficient data port, whether the host acknowledged it or not. The slave's own 7-bit bus address is stored in a writable register. A new value applies only once the current transfer has closed with a stop. The map also holds a fixed identity code, a fixed revision code and a writable subsystem code.

Top module: `i2cs_reg_slave`

## Requirements
- R1: After reset the slave answers bus address 7'b1101001 (write header 0xD2, read header 0xD3). The register pointer is 0x00, every register reads 0x00 except the fixed codes and the address register, and `sda_oe` is 0.
- R2: The slave acknowledges a header only when bits 7:1 match its active address. After a mismatch it drives nothing and ignores every byte until the next start.
- R3: In a write cycle the first data byte loads the pointer. Each later byte is stored at the pointer, and then the pointer steps by one. The pointer wraps from 0xFF to 0x00.
- R4: Read data is sent MSB first. `sda_oe` (1 = pull data low) changes only while the clock line is low, except that a start or stop releases it.
- R5: During a read, a byte that the host acknowledges steps the register pointer by one (wrapping 0xFF to 0x00), and the next byte comes from the new pointer.
- R6: A byte that the host does not acknowledge leaves the register pointer unchanged. A read byte cut short by a start or stop also leaves it unchanged.
- R7: Address 0x70 is the coefficient data port and 0x71 holds the coefficient pointer (read back zero-extended; a write keeps the low log2(depth) bits). Each completed byte read from 0x70 returns the RAM entry at the coefficient pointer and then advances that pointer, with or without host acknowledge. Each write to 0x70 stores the byte and advances the pointer. The pointer wraps from depth-1 to 0.
- R8: Register 0x7C holds the slave address in bits 7:1, which are read/write. Bit 0 always reads 0. A written address governs header matching only after the next stop condition.
- R9: 0x7E returns the identity code (default 0x5A) and 0x7F returns the revision code (default 0x03); writes to them are ignored. 0x7D is a read/write subsystem code.
- R10: 0x00 to 0x07 are read/write general registers. Every other address not named above reads 0x00 and ignores writes.
- R11: A start or stop seen at any bit position abandons the byte in flight. A start begins a fresh header, and a write byte cut short is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest case to reach from the pins is the split between the two pointers. The coefficient pointer must advance on a byte the host refused, while the register pointer stays put. The stimulus reaches it by reading the data port once with a not-acknowledge and then issuing a bare read header with no pointer load. That second byte must be the next coefficient. An acknowledged byte then moves the register pointer onto 0x71, so the coefficient pointer itself appears on the bus. A byte cut off by a stop after four bits is another such case; a following bare read shows that the pointer did not move.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_BITS = 8;

    // Register map positions that the pointer logic decodes
    localparam logic [7:0] RA_COEF_DATA = 8'h70;
    localparam logic [7:0] RA_COEF_PTR  = 8'h71;
    localparam logic [7:0] RA_OWN_ADDR  = 8'h7C;
    localparam logic [7:0] RA_SUBSYS    = 8'h7D;
    localparam logic [7:0] RA_IDENT     = 8'h7E;
    localparam logic [7:0] RA_REVISION  = 8'h7F;

    localparam logic [6:0] OWN_ADDR_RESET = 7'b1101001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } link_state_e;

    // Conditioned bus lines and the events decoded from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_evt_t;

    // Single-cycle requests from the protocol engine to the register bank
    typedef struct packed {
        logic       ptr_load;
        logic       wr_en;
        logic       rd_ack;
        logic       rd_done;
        logic [7:0] data;
    } reg_req_t;

    function automatic logic header_hits(input logic [7:0] hdr, input logic [6:0] own);
        return hdr[7:1] == own;
    endfunction

    function automatic logic [7:0] shift_in(input logic [7:0] cur, input logic bit_in);
        return {cur[6:0], bit_in};
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output i2cs_pkg::line_evt_t  evt
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_ff;
    logic [TOP:0] sda_ff;
    logic         scl_q;
    logic         sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            scl_q     <= scl_ff[TOP];
            sda_q     <= sda_ff[TOP];
        end
    end

    generate
        for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_ff[s] <= 1'b1;
                    sda_ff[s] <= 1'b1;
                end else begin
                    scl_ff[s] <= scl_ff[s-1];
                    sda_ff[s] <= sda_ff[s-1];
                end
            end
        end
    endgenerate

    always_comb begin
        evt.scl      = scl_ff[TOP];
        evt.sda      = sda_ff[TOP];
        evt.scl_rise = scl_ff[TOP] & ~scl_q;
        evt.scl_fall = ~scl_ff[TOP] & scl_q;
        evt.start    = scl_q & scl_ff[TOP] & sda_q & ~sda_ff[TOP];
        evt.stop     = scl_q & scl_ff[TOP] & ~sda_q & sda_ff[TOP];
    end

endmodule

// File: rtl/i2cs_link.sv
module i2cs_link
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_evt_t  evt,
    input  logic [6:0] own_addr,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output reg_req_t   req
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

    link_state_e st;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg;
    logic        is_read;
    logic        first_byte;
    logic        host_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            is_read    <= 1'b0;
            first_byte <= 1'b0;
            host_ack   <= 1'b0;
            sda_oe     <= 1'b0;
            req        <= '0;
        end else begin
            req.ptr_load <= 1'b0;
            req.wr_en    <= 1'b0;
            req.rd_ack   <= 1'b0;
            req.rd_done  <= 1'b0;
            if (evt.start) begin
                st     <= ST_HDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_IDLE: ;
                    ST_HDR, ST_WR_BYTE: begin
                        if (evt.scl_rise) begin
                            shreg  <= shift_in(shreg, evt.sda);
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall && bitcnt == LAST_BIT) begin
                            bitcnt <= '0;
                            if (st == ST_HDR) begin
                                if (header_hits(shreg, own_addr)) begin
                                    st         <= ST_HDR_ACK;
                                    sda_oe     <= 1'b1;
                                    is_read    <= shreg[0];
                                    first_byte <= ~shreg[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                st       <= ST_WR_ACK;
                                sda_oe   <= 1'b1;
                                req.data <= shreg;
                                if (first_byte) req.ptr_load <= 1'b1;
                                else            req.wr_en    <= 1'b1;
                            end
                        end
                    end
                    ST_HDR_ACK: begin
                        if (evt.scl_fall) begin
                            if (is_read) begin
                                st     <= ST_RD_BYTE;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                st     <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (evt.scl_fall) begin
                            st         <= ST_WR_BYTE;
                            sda_oe     <= 1'b0;
                            first_byte <= 1'b0;
                        end
                    end
                    ST_RD_BYTE: begin
                        if (evt.scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (bitcnt == LAST_BIT) begin
                                st          <= ST_RD_ACK;
                                sda_oe      <= 1'b0;
                                bitcnt      <= '0;
                                req.rd_done <= 1'b1;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (evt.scl_rise) begin
                            host_ack   <= ~evt.sda;
                            req.rd_ack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            if (host_ack) begin
                                st     <= ST_RD_BYTE;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // The drive enable moves only in the bus clock low phase, or is dropped by a start/stop
    assert_oe_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> (!evt.scl || $past(evt.start || evt.stop)));

    // An idle slave (including after a header mismatch) never holds the line
    assert_idle_released_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
    import i2cs_pkg::*;
#(
    parameter int         NUM_GP     = 8,
    parameter int         COEF_DEPTH = 16,
    parameter logic [7:0] IDENT_CODE = 8'h5A,
    parameter logic [7:0] REV_CODE   = 8'h03
) (
    input  logic       clk,
    input  logic       rst,
    input  reg_req_t   req,
    input  logic       stop_evt,
    output logic [6:0] own_addr,
    output logic [7:0] rd_data
);
    localparam int             GPW       = $clog2(NUM_GP);
    localparam int             CPW       = $clog2(COEF_DEPTH);
    localparam logic [7:0]     GP_END    = 8'(NUM_GP);
    localparam logic [CPW-1:0] COEF_LAST = CPW'(COEF_DEPTH - 1);

    logic [7:0]     ptr;
    logic [7:0]     gp [NUM_GP];
    logic [7:0]     coef [COEF_DEPTH];
    logic [CPW-1:0] coef_ptr;
    logic [CPW-1:0] coef_next;
    logic [6:0]     addr_stored;
    logic [7:0]     subsys;
    logic           coef_we;
    logic           coef_rd_step;

    assign coef_next    = (coef_ptr == COEF_LAST) ? '0 : coef_ptr + 1'b1;
    assign coef_we      = req.wr_en && (ptr == RA_COEF_DATA);
    assign coef_rd_step = req.rd_done && (ptr == RA_COEF_DATA);

    // Register pointer: load on first write byte, step on stored byte or host ACK
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (req.ptr_load) begin
            ptr <= req.data;
        end else if (req.wr_en || req.rd_ack) begin
            ptr <= ptr + 8'd1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
            always_ff @(posedge clk) begin
                if (rst)                                gp[g] <= '0;
                else if (req.wr_en && ptr == 8'(g))     gp[g] <= req.data;
            end
        end
    endgenerate

    // Coefficient storage and its own pointer
    always_ff @(posedge clk) begin
        if (coef_we) coef[coef_ptr] <= req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coef_ptr <= '0;
        end else if (req.wr_en && ptr == RA_COEF_PTR) begin
            coef_ptr <= req.data[CPW-1:0];
        end else if (coef_we || coef_rd_step) begin
            coef_ptr <= coef_next;
        end
    end

    // Own address: stored value updates on write, active value on stop
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_stored <= OWN_ADDR_RESET;
            own_addr    <= OWN_ADDR_RESET;
            subsys      <= '0;
        end else begin
            if (req.wr_en && ptr == RA_OWN_ADDR) addr_stored <= req.data[7:1];
            if (req.wr_en && ptr == RA_SUBSYS)   subsys      <= req.data;
            if (stop_evt)                        own_addr    <= addr_stored;
        end
    end

    always_comb begin
        rd_data = '0;
        if (ptr < GP_END) begin
            rd_data = gp[ptr[GPW-1:0]];
        end else begin
            unique case (ptr)
                RA_COEF_DATA: rd_data = coef[coef_ptr];
                RA_COEF_PTR:  rd_data = 8'(coef_ptr);
                RA_OWN_ADDR:  rd_data = {addr_stored, 1'b0};
                RA_SUBSYS:    rd_data = subsys;
                RA_IDENT:     rd_data = IDENT_CODE;
                RA_REVISION:  rd_data = REV_CODE;
                default:      rd_data = '0;
            endcase
        end
    end

    assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(req.ptr_load || req.wr_en || req.rd_ack) |=> $stable(ptr));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!req.ptr_load && (req.rd_ack || req.wr_en)) |=> (ptr == $past(ptr) + 8'd1));

    assert_coef_step_R7: assert property (@(posedge clk) disable iff (rst)
        coef_rd_step |=> (coef_ptr == (($past(coef_ptr) == COEF_LAST) ? '0 : $past(coef_ptr) + 1'b1)));

    assert_addr_on_stop_R8: assert property (@(posedge clk) disable iff (rst)
        !stop_evt |=> $stable(own_addr));

endmodule

// File: rtl/i2cs_reg_slave.sv
module i2cs_reg_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_GP      = 8,
    parameter int         COEF_DEPTH  = 16,
    parameter logic [7:0] IDENT_CODE  = 8'h5A,
    parameter logic [7:0] REV_CODE    = 8'h03
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    i2cs_pkg::line_evt_t evt;
    i2cs_pkg::reg_req_t  req;
    logic [6:0]          own_addr;
    logic [7:0]          rd_data;

    i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2cs_link u_link (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .own_addr (own_addr),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .req      (req)
    );

    i2cs_regbank #(
        .NUM_GP     (NUM_GP),
        .COEF_DEPTH (COEF_DEPTH),
        .IDENT_CODE (IDENT_CODE),
        .REV_CODE   (REV_CODE)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .stop_evt (evt.stop),
        .own_addr (own_addr),
        .rd_data  (rd_data)
    );

endmodule

// File: tb/i2cs_reg_slave_tb.sv
module i2cs_reg_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int oe_viol = 0;
    bit done = 1'b0;
    logic [7:0] dev_w = 8'hD2;

    assign sda_line = sda_h & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2cs_reg_slave u_dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_h),
        .sda_i  (sda_line),
        .sda_oe (sda_oe)
    );

    // R4 monitor: drive enable must not move while the clock line is held high
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    always @(negedge clk) begin
        if (!rst && scl_h && scl_prev && (sda_oe !== oe_prev)) oe_viol++;
        oe_prev  <= sda_oe;
        scl_prev <= scl_h;
    end

    // {register address, value written, value expected on readback}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'h11, 8'h11},
        {8'h05, 8'hA5, 8'hA5},
        {8'h07, 8'h3C, 8'h3C},
        {8'h7D, 8'hC3, 8'hC3},
        {8'h7E, 8'hFF, 8'h5A},
        {8'h7F, 8'h00, 8'h03},
        {8'h08, 8'h12, 8'h00},
        {8'h7B, 8'h66, 8'h00}
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b1; wait_q(); wait_q();
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; wait_q();
        scl_h = 1'b1; wait_q(); wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic recv_bit(output logic b);
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        b = sda_line; wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic nack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(nack);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(~give_ack);
    endtask

    task automatic send_acked(input logic [7:0] v);
        logic nk;
        send_byte(v, nk);
        check8("R2 byte acknowledged", {7'd0, nk}, 8'd0);
    endtask

    task automatic reg_write(input logic [7:0] ra, input logic [7:0] v);
        bus_start(); send_acked(dev_w); send_acked(ra); send_acked(v); bus_stop();
    endtask

    task automatic set_ptr(input logic [7:0] ra);
        bus_start(); send_acked(dev_w); send_acked(ra); bus_stop();
    endtask

    task automatic reg_read(input logic [7:0] ra, output logic [7:0] v);
        bus_start(); send_acked(dev_w); send_acked(ra);
        bus_start(); send_acked(dev_w | 8'h01);
        recv_byte(1'b0, v); bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] v);
        bus_start(); send_acked(dev_w | 8'h01);
        recv_byte(1'b0, v); bus_stop();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic nk;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state
        check8("R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
        cur_read(d);           check8("R1 pointer at 0x00", d, 8'h00);
        reg_read(8'h7C, d);    check8("R1 address register", d, 8'hD2);
        reg_read(8'h7D, d);    check8("R1 subsystem reset", d, 8'h00);

        // R2: foreign header ignored, pointer stays at 0x7D
        bus_start();
        send_byte(8'hA0, nk); check8("R2 foreign header not acked", {7'd0, nk}, 8'd1);
        send_byte(8'h7E, nk); check8("R2 following byte not acked", {7'd0, nk}, 8'd1);
        bus_stop();
        cur_read(d);          check8("R2 pointer untouched", d, 8'h00);

        // R9 R10: table walk
        for (int i = 0; i < 8; i++) begin
            reg_write(VEC[i][23:16], VEC[i][15:8]);
            reg_read(VEC[i][23:16], d);
            check8($sformatf("R9/R10 table %0d", i), d, VEC[i][7:0]);
        end

        // R3 R5 R6: burst write then burst read
        bus_start(); send_acked(dev_w); send_acked(8'h00);
        send_acked(8'h10); send_acked(8'h20); send_acked(8'h30); send_acked(8'h40);
        bus_stop();
        bus_start(); send_acked(dev_w); send_acked(8'h00);
        bus_start(); send_acked(dev_w | 8'h01);
        recv_byte(1'b1, d); check8("R3 burst byte 0", d, 8'h10);
        recv_byte(1'b1, d); check8("R5 burst byte 1", d, 8'h20);
        recv_byte(1'b1, d); check8("R5 burst byte 2", d, 8'h30);
        recv_byte(1'b0, d); check8("R5 burst byte 3", d, 8'h40);
        bus_stop();
        cur_read(d);        check8("R6 NACK holds pointer", d, 8'h40);

        // R3 R5: wrap 0xFF -> 0x00
        bus_start(); send_acked(dev_w); send_acked(8'hFF);
        send_acked(8'h99); send_acked(8'h55); bus_stop();
        reg_read(8'h00, d); check8("R3 write wraps", d, 8'h55);
        bus_start(); send_acked(dev_w); send_acked(8'hFF);
        bus_start(); send_acked(dev_w | 8'h01);
        recv_byte(1'b1, d); check8("R10 0xFF reads zero", d, 8'h00);
        recv_byte(1'b0, d); check8("R5 read wraps", d, 8'h55);
        bus_stop();

        // R6 R11: read cut short by stop
        reg_write(8'h07, 8'hFF);
        set_ptr(8'h07);
        bus_start(); send_acked(dev_w | 8'h01);
        for (int i = 0; i < 4; i++) recv_bit(nk);
        bus_stop();
        cur_read(d); check8("R6 aborted read holds pointer", d, 8'hFF);

        // R11: write cut short by stop is not stored
        bus_start(); send_acked(dev_w); send_acked(8'h01);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_stop();
        reg_read(8'h01, d); check8("R11 aborted write", d, 8'h20);

        // R11: repeated start mid-byte starts a new header
        bus_start(); send_acked(dev_w); send_acked(8'h02);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start(); send_acked(dev_w | 8'h01);
        recv_byte(1'b0, d); bus_stop();
        check8("R11 restart mid-byte", d, 8'h30);

        // R7: coefficient port
        reg_write(8'h71, 8'h00);
        for (int k = 0; k < 4; k++) reg_write(8'h70, 8'hC0 + 8'(k));
        reg_read(8'h71, d); check8("R7 write advances coef pointer", d, 8'h04);
        reg_write(8'h71, 8'h00);
        reg_read(8'h70, d); check8("R7 coef entry 0", d, 8'hC0);
        cur_read(d);        check8("R7 coef advanced on NACK", d, 8'hC1);
        bus_start(); send_acked(dev_w | 8'h01);
        recv_byte(1'b1, d); check8("R7 coef entry 2", d, 8'hC2);
        recv_byte(1'b0, d); check8("R7 coef pointer after reads", d, 8'h03);
        bus_stop();
        reg_write(8'h71, 8'h0F);
        reg_write(8'h70, 8'hE1);
        reg_read(8'h71, d); check8("R7 coef pointer wraps", d, 8'h00);

        // R8: own address change applies after stop
        bus_start(); send_acked(dev_w); send_acked(8'h7C); send_acked(8'h80);
        bus_start();
        send_byte(8'hD3, nk); check8("R8 old address until stop", {7'd0, nk}, 8'd0);
        recv_byte(1'b0, d);   check8("R8 read continues at 0x7D", d, 8'hC3);
        bus_stop();
        bus_start();
        send_byte(8'hD2, nk); check8("R8 old address dropped", {7'd0, nk}, 8'd1);
        bus_stop();
        dev_w = 8'h80;
        reg_read(8'h7C, d);   check8("R8 new address readback", d, 8'h80);
        reg_write(8'h7C, 8'hD3);
        dev_w = 8'hD2;
        reg_read(8'h7C, d);   check8("R8 bit 0 reads zero", d, 8'hD2);

        // R4: drive enable never moved with clock high
        check8("R4 oe stable while clock high", 8'(oe_viol), 8'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule